// File: doc/BRIEF.md
# RTC Interrupt Request and Reset Controller

This block holds the interrupt logic of a real-time clock. Three event sources feed it: a periodic tick, an alarm match and an update-complete notice, each arriving as a one-cycle pulse from the timekeeping logic outside the block. Each source owns a sticky event flag and an enable bit. When some flag is set and its enable is also set, the block raises a summary request flag and asserts the output-enable of an active-low, open-drain interrupt line. A host bus writes the enables and a square-wave enable through a control register. It reads the flags back through a status register, and that read clears them.

An external active-low reset pin forces a fixed set of control bits and flags to zero and locks the host out while it is held low. Main-power status gates all host access. Timekeeping and general-purpose memory are not stored here and are left untouched by the pin. The system reset `rst_n` is asynchronous and is released through a two-stage synchronizer.

Top module: `rtc_irq_ctrl`

## Requirements
- R1: While `ext_rst_n` is low and `pwr_ok` is high, all three interrupt enables are forced to 0. This shows in control register bits 2:0 after release.
- R2: While `ext_rst_n` is low, all three event flags and the summary flag are cleared, whatever the state of `pwr_ok`.
- R3: While `ext_rst_n` is low, the square-wave enable is cleared. Host writes are dropped, and a host read returns 0 and clears nothing.
- R4: While `pwr_ok` is low, host reads and writes are ignored (a read returns 0). If `ext_rst_n` is low while `pwr_ok` is low, the enables keep their values.
- R5: `irq_oe` (line driven low) is 1 exactly when some flag is set together with its matching enable. Otherwise it is 0 (high impedance).
- R6: An accepted read of the status register (address 1) returns bit 7 = summary, bit 2 = periodic, bit 1 = alarm, bit 0 = update, and all other bits 0. It clears all flags at the same clock edge, which releases `irq_oe`.
- R7: A source pulse sets its flag whatever its enable is, so software can poll.
- R8: If a source pulse and a status read fall in the same cycle, that source's flag remains set afterwards.
- R9: The control register (address 0) holds update enable in bit 0, alarm enable in bit 1, periodic enable in bit 2 and square-wave enable in bit 3. It reads back the same way. Other addresses read 0.
- R10: `host_rdata` is registered. It carries the read value in the cycle after an accepted read and 0 in every other cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low system reset |
| pwr_ok | input | 1 | Main power within limits |
| ext_rst_n | input | 1 | Active-low external reset pin |
| host_rd | input | 1 | Host read strobe |
| host_wr | input | 1 | Host write strobe |
| host_addr | input | 2 | Register address |
| host_wdata | input | 8 | Write data |
| host_rdata | output | 8 | Registered read data |
| evt_periodic | input | 1 | Periodic event pulse |
| evt_alarm | input | 1 | Alarm event pulse |
| evt_update | input | 1 | Update-ended event pulse |
| irq_oe | output | 1 | Drive the active-low request line low |
| sqw_en | output | 1 | Square-wave output enable |

## Verification
The hardest case to reach is a source pulse that lands in the same cycle as a status read. The read must report the old flags, and the new flag must survive the clear. The stimulus lines this up by raising the pulse and the read strobe on the same falling edge, then reads again to see the kept flag. The case where power is lost while the pin is held low is also hard to reach. It is built by dropping `pwr_ok` before pulling the pin low, then reading the control register back after both recover. A behavioural model also tracks every cycle, including the reset windows.

// File: rtl/rtc_irq_pkg.sv
package rtc_irq_pkg;
  localparam int SRC_N     = 3;
  localparam int SRC_UPD   = 0;
  localparam int SRC_ALM   = 1;
  localparam int SRC_PER   = 2;
  localparam int CTRL_ADDR = 0;
  localparam int STAT_ADDR = 1;
  localparam int SQW_BIT   = 3;
  localparam int SUM_BIT   = 7;
endpackage

// File: rtl/rtc_irq_rst_sync.sv
module rtc_irq_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = chain_q[STAGES-1];
endmodule

// File: rtl/rtc_irq_source.sv
module rtc_irq_source (
  input  logic clk,
  input  logic rst_n,
  input  logic evt,
  input  logic clr_rd,
  input  logic clr_pin,
  output logic flag
);
  logic flag_q, flag_d;

  always_comb begin
    flag_d = flag_q;
    if (clr_pin)     flag_d = 1'b0;
    else if (evt)    flag_d = 1'b1;
    else if (clr_rd) flag_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flag_q <= 1'b0;
    else        flag_q <= flag_d;
  end

  assign flag = flag_q;

  assert_evt_sets_R7: assert property (@(posedge clk) disable iff (!rst_n)
    evt && !clr_pin |=> flag);
  assert_evt_wins_read_R8: assert property (@(posedge clk) disable iff (!rst_n)
    evt && clr_rd && !clr_pin |=> flag);
  assert_pin_clears_R2: assert property (@(posedge clk) disable iff (!rst_n)
    clr_pin |=> !flag);
endmodule

// File: rtl/rtc_irq_ctrl_regs.sv
module rtc_irq_ctrl_regs #(
  parameter int SRC_N  = rtc_irq_pkg::SRC_N,
  parameter int ADDR_W = 2,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              host_ok,
  input  logic              force_en_clr,
  input  logic              force_sqw_clr,
  input  logic              wr,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [SRC_N-1:0]  en,
  output logic              sqw_en
);
  import rtc_irq_pkg::*;

  logic [SRC_N-1:0] en_q, en_d;
  logic             sqw_q, sqw_d;
  logic             wr_ctrl;

  assign wr_ctrl = host_ok && wr && (addr == ADDR_W'(CTRL_ADDR));

  always_comb begin
    en_d  = en_q;
    sqw_d = sqw_q;
    if (force_en_clr) en_d = '0;
    else if (wr_ctrl) en_d = wdata[SRC_N-1:0];
    if (force_sqw_clr) sqw_d = 1'b0;
    else if (wr_ctrl)  sqw_d = wdata[SQW_BIT];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q  <= '0;
      sqw_q <= 1'b0;
    end else begin
      en_q  <= en_d;
      sqw_q <= sqw_d;
    end
  end

  assign en     = en_q;
  assign sqw_en = sqw_q;

  assert_en_forced_R1: assert property (@(posedge clk) disable iff (!rst_n)
    force_en_clr |=> en == '0);
  assert_sqw_cleared_R3: assert property (@(posedge clk) disable iff (!rst_n)
    force_sqw_clr |=> !sqw_en);
  assert_locked_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !host_ok && !force_en_clr |=> $stable(en));
endmodule

// File: rtl/rtc_irq_ctrl.sv
module rtc_irq_ctrl #(
  parameter int ADDR_W = 2,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pwr_ok,
  input  logic              ext_rst_n,
  input  logic              host_rd,
  input  logic              host_wr,
  input  logic [ADDR_W-1:0] host_addr,
  input  logic [DATA_W-1:0] host_wdata,
  output logic [DATA_W-1:0] host_rdata,
  input  logic              evt_periodic,
  input  logic              evt_alarm,
  input  logic              evt_update,
  output logic              irq_oe,
  output logic              sqw_en
);
  import rtc_irq_pkg::*;

  logic              rst_sync_n;
  logic              host_ok, pin_active, rd_stat;
  logic [SRC_N-1:0]  evt, flags, en;
  logic              irqf;
  logic [DATA_W-1:0] rdata_q, rdata_d;

  rtc_irq_rst_sync #(.STAGES(2)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_sync_n(rst_sync_n)
  );

  assign pin_active = !ext_rst_n;
  assign host_ok    = ext_rst_n && pwr_ok;
  assign rd_stat    = host_ok && host_rd && (host_addr == ADDR_W'(STAT_ADDR));

  always_comb begin
    evt          = '0;
    evt[SRC_UPD] = evt_update;
    evt[SRC_ALM] = evt_alarm;
    evt[SRC_PER] = evt_periodic;
  end

  for (genvar i = 0; i < SRC_N; i++) begin : g_src
    rtc_irq_source u_src (
      .clk(clk), .rst_n(rst_sync_n), .evt(evt[i]),
      .clr_rd(rd_stat), .clr_pin(pin_active), .flag(flags[i])
    );
  end

  rtc_irq_ctrl_regs #(.SRC_N(SRC_N), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_regs (
    .clk(clk), .rst_n(rst_sync_n), .host_ok(host_ok),
    .force_en_clr(pin_active && pwr_ok), .force_sqw_clr(pin_active),
    .wr(host_wr), .addr(host_addr), .wdata(host_wdata),
    .en(en), .sqw_en(sqw_en)
  );

  assign irqf   = |(flags & en);
  assign irq_oe = irqf;

  always_comb begin
    rdata_d = '0;
    if (host_ok && host_rd) begin
      if (host_addr == ADDR_W'(CTRL_ADDR)) begin
        rdata_d[SRC_N-1:0] = en;
        rdata_d[SQW_BIT]   = sqw_en;
      end else if (host_addr == ADDR_W'(STAT_ADDR)) begin
        rdata_d[SRC_N-1:0] = flags;
        rdata_d[SUM_BIT]   = irqf;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) rdata_q <= '0;
    else             rdata_q <= rdata_d;
  end

  assign host_rdata = rdata_q;

  assert_read_release_R6: assert property (@(posedge clk) disable iff (!rst_sync_n)
    rd_stat && (evt == '0) |=> !irq_oe);
  assert_locked_rdata_R3: assert property (@(posedge clk) disable iff (!rst_sync_n)
    pin_active |=> host_rdata == '0);
  assert_unpowered_rdata_R4: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !pwr_ok |=> host_rdata == '0);
  assert_idle_rdata_R10: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !host_rd |=> host_rdata == '0);
endmodule

// File: tb/tb_rtc_irq_ctrl.sv
`timescale 1ns/1ps
module tb_rtc_irq_ctrl;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       pwr_ok = 1'b1, ext_rst_n = 1'b1;
  logic       host_rd = 1'b0, host_wr = 1'b0;
  logic [1:0] host_addr = '0;
  logic [7:0] host_wdata = '0;
  logic [7:0] host_rdata;
  logic       evt_periodic = 1'b0, evt_alarm = 1'b0, evt_update = 1'b0;
  logic       irq_oe, sqw_en;

  int checks = 0, fails = 0;
  bit done = 0;

  // reference state: bit order upd=0, alm=1, per=2
  int m_flag[3];
  int m_en[3];
  int m_sqw = 0;
  int m_rdata = 0;

  always #2.5 clk = ~clk;

  rtc_irq_ctrl dut (
    .clk(clk), .rst_n(rst_n), .pwr_ok(pwr_ok), .ext_rst_n(ext_rst_n),
    .host_rd(host_rd), .host_wr(host_wr), .host_addr(host_addr),
    .host_wdata(host_wdata), .host_rdata(host_rdata),
    .evt_periodic(evt_periodic), .evt_alarm(evt_alarm), .evt_update(evt_update),
    .irq_oe(irq_oe), .sqw_en(sqw_en)
  );

  function automatic int m_irq();
    int r = 0;
    for (int i = 0; i < 3; i++) if (m_flag[i] != 0 && m_en[i] != 0) r = 1;
    return r;
  endfunction

  always @(posedge clk) begin
    int ev[3];
    int ok, nrd;
    if (!rst_n) begin
      for (int i = 0; i < 3; i++) begin m_flag[i] = 0; m_en[i] = 0; end
      m_sqw = 0; m_rdata = 0;
    end else begin
      ev[0] = evt_update; ev[1] = evt_alarm; ev[2] = evt_periodic;
      ok  = (ext_rst_n && pwr_ok) ? 1 : 0;
      nrd = 0;
      if (ok && host_rd) begin
        if (host_addr == 0) nrd = m_en[0] + 2*m_en[1] + 4*m_en[2] + 8*m_sqw;
        else if (host_addr == 1) nrd = m_flag[0] + 2*m_flag[1] + 4*m_flag[2] + 128*m_irq();
      end
      m_rdata = nrd;
      for (int i = 0; i < 3; i++) begin
        if (!ext_rst_n) m_flag[i] = 0;
        else if (ev[i] != 0) m_flag[i] = 1;
        else if (ok && host_rd && host_addr == 1) m_flag[i] = 0;
      end
      if (!ext_rst_n) begin
        m_sqw = 0;
        if (pwr_ok) for (int i = 0; i < 3; i++) m_en[i] = 0;
      end else if (ok && host_wr && host_addr == 0) begin
        for (int i = 0; i < 3; i++) m_en[i] = host_wdata[i];
        m_sqw = host_wdata[3];
      end
    end
  end

  task automatic check(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  // model comparison every cycle, away from the active edge
  always @(negedge clk) begin
    if (rst_n && !done) begin
      check("R5", "model irq_oe", int'(irq_oe), m_irq());
      check("R3", "model sqw_en", int'(sqw_en), m_sqw);
      check("R10", "model host_rdata", int'(host_rdata), m_rdata);
    end
  end

  task automatic cyc();
    @(posedge clk); @(negedge clk);
  endtask

  task automatic wr(input int a, input int d);
    host_wr = 1; host_addr = 2'(a); host_wdata = 8'(d);
    cyc();
    host_wr = 0;
  endtask

  task automatic rd(input int a);
    host_rd = 1; host_addr = 2'(a);
    cyc();
    host_rd = 0;
  endtask

  task automatic finish_run();
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    #(5.0 * 20000);
    fails++; checks++;
    $display("FAIL watchdog: actual hung expected finish");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (4) @(negedge clk);
    check("R5", "reset irq_oe", int'(irq_oe), 0);
    check("R3", "reset sqw_en", int'(sqw_en), 0);
    check("R10", "reset rdata", int'(host_rdata), 0);

    wr(0, 8'h07);
    rd(0);
    check("R9", "ctrl readback", int'(host_rdata), 8'h07);
    cyc();
    check("R10", "rdata after read", int'(host_rdata), 0);

    evt_alarm = 1; cyc(); evt_alarm = 0;
    check("R5", "alarm irq", int'(irq_oe), 1);
    rd(1);
    check("R6", "status alarm", int'(host_rdata), 8'h82);
    check("R6", "irq released", int'(irq_oe), 0);

    wr(0, 8'h00);
    evt_periodic = 1; cyc(); evt_periodic = 0;
    check("R5", "masked irq", int'(irq_oe), 0);
    rd(1);
    check("R7", "poll periodic", int'(host_rdata), 8'h04);

    evt_update = 1; host_rd = 1; host_addr = 2'd1; cyc();
    evt_update = 0; host_rd = 0;
    check("R8", "read with pulse", int'(host_rdata), 8'h00);
    rd(1);
    check("R8", "update kept", int'(host_rdata), 8'h01);

    rd(2);
    check("R9", "unmapped read", int'(host_rdata), 0);

    wr(0, 8'h0F);
    check("R9", "sqw set", int'(sqw_en), 1);
    evt_alarm = 1; cyc(); evt_alarm = 0;
    check("R5", "irq before pin", int'(irq_oe), 1);
    ext_rst_n = 0; cyc();
    check("R2", "pin clears irq", int'(irq_oe), 0);
    check("R3", "pin clears sqw", int'(sqw_en), 0);
    host_wr = 1; host_addr = 0; host_wdata = 8'h07; cyc(); host_wr = 0;
    rd(1);
    check("R3", "locked read", int'(host_rdata), 0);
    ext_rst_n = 1; cyc();
    rd(0);
    check("R1", "enables cleared", int'(host_rdata), 0);
    rd(1);
    check("R2", "flags cleared", int'(host_rdata), 0);

    wr(0, 8'h07);
    pwr_ok = 0; cyc();
    wr(0, 8'h00);
    rd(0);
    check("R4", "unpowered read", int'(host_rdata), 0);
    ext_rst_n = 0; cyc(); cyc();
    ext_rst_n = 1; cyc();
    pwr_ok = 1; cyc();
    rd(0);
    check("R4", "enables kept", int'(host_rdata), 8'h07);

    evt_update = 1; evt_periodic = 1; cyc(); evt_update = 0; evt_periodic = 0;
    rd(1);
    check("R6", "two flags", int'(host_rdata), 8'h85);
    repeat (3) cyc();
    finish_run();
  end
endmodule